// File: doc/BRIEF.md
# Absmean ternary weight quantizer

This block turns a block of signed 16-bit fixed-point master weights into ternary codes (-1, 0, +1) scaled against the block's own mean magnitude. It runs in two phases. In the gathering phase it takes weights from a valid/ready input stream, stores them in a local buffer and sums their absolute values. In the emitting phase it replays the stored weights in the order they arrived and emits one 2-bit code per weight, with the mean magnitude on a 16-bit scale word beside each code.

No divider is used. A weight maps to a nonzero code when twice the block length times its magnitude reaches the magnitude sum plus the block length times a small positive integer epsilon. This is the same test as rounding w / (mean + epsilon) to the nearest integer and clipping the result to [-1, +1], with ties rounding away from zero. A zero code switches the matching input channel off.

The block length `DEPTH` is a power of two, so the mean is a right shift of the sum. A block closes on its `DEPTH`-th weight, or earlier when a weight arrives with `in_last` set. A short block counts as zero-padded to `DEPTH` for the statistics.

Top module: `tq_absmean`

## Requirements
- R1: After a synchronous active-low reset, `in_ready` is 1 and `out_valid` is 0.
- R2: `out_scale` equals floor(sum of |w| over the block / DEPTH), and it is the same on every code of a block.
- R3: A weight w gets a nonzero code when 2·DEPTH·|w| ≥ sum|W| + DEPTH·EPS, with the sign of w, and code zero otherwise. An exact tie gives the nonzero code.
- R4: Codes are 2'b00 for zero, 2'b01 for +1 and 2'b11 for -1. 2'b10 never appears on a valid output.
- R5: The most negative input, -32768, counts with magnitude 32768 in the sum and in the compare, with no overflow.
- R6: `in_ready` is 0 for the whole emitting phase, so an offered weight is not taken until the final code of the block has been accepted. The cycle after that acceptance, `in_ready` is 1 again.
- R7: Codes come out in input order, one per stored weight, and `out_last` is set only on the final code of the block.
- R8: A block closes on the DEPTH-th weight even when `in_last` is low. A block closed early by `in_last` after L weights emits exactly L codes, and its mean is still taken over DEPTH.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_code`, `out_scale` and `out_last` all hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input weight offered |
| in_ready | output | 1 | Block accepts a weight (gathering phase) |
| in_data | input | WIDTH | Signed two's-complement master weight |
| in_last | input | 1 | Marks the final weight of a short block |
| out_valid | output | 1 | Ternary code available |
| out_ready | input | 1 | Downstream accepts the code |
| out_code | output | 2 | Ternary code: 00 zero, 01 plus one, 11 minus one |
| out_scale | output | WIDTH | Mean magnitude of the block |
| out_last | output | 1 | Final code of the block |

## Verification
The properties assume that reset is asserted from time zero and that `out_ready` is a known level at every clock edge. They assume nothing about how `in_valid` behaves while the block is emitting. The stimulus drives every input one nanosecond after the rising edge and never leaves one unknown. It offers the first weight of the next block while the current block is still emitting, which exercises the refusal to accept input in that phase. It also holds `out_ready` low on an irregular pattern in later blocks, so the hold rule is exercised on codes in the middle of a block and on final codes.

// File: rtl/tq_pkg.sv
// Shared types for the absmean ternary quantizer.
// Assumes nothing beyond IEEE 1800-2017 enums.
package tq_pkg;

    // Ternary output codes; 2'b10 is reserved and never produced.
    typedef enum logic [1:0] {
        TQ_ZERO = 2'b00,
        TQ_POS  = 2'b01,
        TQ_NEG  = 2'b11
    } tq_code_e;

    // Block phase: gather statistics or emit codes.
    typedef enum logic {
        PH_GATHER = 1'b0,
        PH_EMIT   = 1'b1
    } tq_phase_e;

endpackage

// File: rtl/tq_mag.sv
// Magnitude of a two's-complement word.
// The result is read as unsigned, so the most negative input maps to
// 2^(WIDTH-1) without overflow. Pure combinational logic.
module tq_mag #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] val,
    output logic [WIDTH-1:0] mag
);

    // Negate negative inputs; the unsigned result holds 2^(WIDTH-1).
    always_comb begin
        if (val[WIDTH-1]) begin
            mag = ~val + 1'b1;
        end else begin
            mag = val;
        end
    end

endmodule

// File: rtl/tq_gather.sv
// Statistics pass: counts accepted weights and accumulates their
// magnitudes in a sum wide enough for DEPTH full-scale magnitudes.
// Assumes DEPTH is a power of two. 'clear' takes priority over 'take'.
module tq_gather #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int SUMW = WIDTH + AW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            take,
    input  logic [WIDTH-1:0] wdata,
    output logic [SUMW-1:0] sum,
    output logic [AW-1:0]   idx,
    output logic            full
);

    logic [WIDTH-1:0] mag;

    tq_mag #(.WIDTH(WIDTH)) u_mag (
        .val (wdata),
        .mag (mag)
    );

    // Accumulate magnitudes and advance the write index per accepted weight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum <= '0;
            idx <= '0;
        end else if (clear) begin
            sum <= '0;
            idx <= '0;
        end else if (take) begin
            sum <= sum + SUMW'(mag);
            idx <= idx + 1'b1;
        end
    end

    // Flag the final slot of the block.
    assign full = (idx == AW'(DEPTH - 1));

endmodule

// File: rtl/tq_store.sv
// Weight buffer of DEPTH entries: one synchronous write port and one
// combinational read port. Entries hold no reset value; reads only
// touch slots written in the current block.
module tq_store #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    // Write one weight per accepted input beat.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Replay read path.
    assign rdata = mem[raddr];

endmodule

// File: rtl/tq_decide.sv
// Ternary decision without a divider. A weight gets a nonzero code
// when 2*DEPTH*|w| >= sum + DEPTH*EPS, with the sign of w.
// Assumes DEPTH is a power of two, EPS >= 1 and EPS < 2^16.
module tq_decide #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 16,
    parameter int EPS   = 1,
    localparam int AW   = $clog2(DEPTH),
    localparam int SUMW = WIDTH + AW,
    localparam int CMPW = WIDTH + AW + 18
) (
    input  logic [WIDTH-1:0] weight,
    input  logic [SUMW-1:0]  sum,
    output tq_pkg::tq_code_e code
);

    localparam logic [CMPW-1:0] BIAS = CMPW'(DEPTH) * CMPW'(EPS);

    logic [WIDTH-1:0] mag;
    logic [CMPW-1:0]  lhs;
    logic [CMPW-1:0]  rhs;

    tq_mag #(.WIDTH(WIDTH)) u_mag (
        .val (weight),
        .mag (mag)
    );

    // Scale both sides so the compare replaces the divide.
    always_comb begin
        lhs = CMPW'(mag) << (AW + 1);
        rhs = CMPW'(sum) + BIAS;
    end

    // Pick the code; equality counts as nonzero (ties round away from zero).
    always_comb begin
        if (lhs >= rhs) begin
            code = weight[WIDTH-1] ? tq_pkg::TQ_NEG : tq_pkg::TQ_POS;
        end else begin
            code = tq_pkg::TQ_ZERO;
        end
    end

endmodule

// File: rtl/tq_absmean.sv
// Absmean ternary weight quantizer, top level.
// Gathering phase: accept up to DEPTH weights, store them and sum their
// magnitudes. Emitting phase: replay the stored weights as ternary codes
// with the mean magnitude beside each one. Input is refused while
// emitting. Assumes DEPTH is a power of two >= 2 and 1 <= EPS < 2^16.
module tq_absmean #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 16,
    parameter int EPS   = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WIDTH-1:0] in_data,
    input  logic             in_last,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [1:0]       out_code,
    output logic [WIDTH-1:0] out_scale,
    output logic             out_last
);

    import tq_pkg::*;

    localparam int AW   = $clog2(DEPTH);
    localparam int SUMW = WIDTH + AW;

    tq_phase_e        phase;
    logic [AW-1:0]    rd_ptr;
    logic [AW-1:0]    last_idx;
    logic [SUMW-1:0]  sum;
    logic [AW-1:0]    wr_idx;
    logic             full;
    logic             take;
    logic             close_blk;
    logic             give;
    logic             done;
    logic [WIDTH-1:0] replay_w;
    tq_code_e         code;

    // Handshake qualifiers for both phases.
    always_comb begin
        in_ready  = (phase == PH_GATHER);
        out_valid = (phase == PH_EMIT);
        take      = in_ready && in_valid;
        close_blk = take && (in_last || full);
        give      = out_valid && out_ready;
        done      = give && (rd_ptr == last_idx);
    end

    tq_gather #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_gather (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (done),
        .take  (take),
        .wdata (in_data),
        .sum   (sum),
        .idx   (wr_idx),
        .full  (full)
    );

    tq_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (take),
        .waddr (wr_idx),
        .wdata (in_data),
        .raddr (rd_ptr),
        .rdata (replay_w)
    );

    tq_decide #(.WIDTH(WIDTH), .DEPTH(DEPTH), .EPS(EPS)) u_decide (
        .weight (replay_w),
        .sum    (sum),
        .code   (code)
    );

    // Phase sequencing: close a block on in_last or a full buffer, reopen after the final code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_GATHER;
            rd_ptr   <= '0;
            last_idx <= '0;
        end else if (phase == PH_GATHER) begin
            if (close_blk) begin
                phase    <= PH_EMIT;
                last_idx <= wr_idx;
                rd_ptr   <= '0;
            end
        end else if (give) begin
            if (done) begin
                phase  <= PH_GATHER;
                rd_ptr <= '0;
            end else begin
                rd_ptr <= rd_ptr + 1'b1;
            end
        end
    end

    // Output word: code, mean magnitude (sum shifted by log2 DEPTH), final flag.
    always_comb begin
        out_code  = code;
        out_scale = sum[SUMW-1:AW];
        out_last  = out_valid && (rd_ptr == last_idx);
    end

endmodule

// File: rtl/tq_absmean_chk.sv
// Protocol checker for tq_absmean, attached with bind. Sees only ports.
// Assumes reset is asserted from time zero and out_ready is never unknown.
module tq_absmean_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [1:0]       out_code,
    input logic [WIDTH-1:0] out_scale,
    input logic             out_last
);

    // R1: reset leaves the block idle and ready for input.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (in_ready && !out_valid));

    // R4: the reserved code never appears.
    p_code_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_code != 2'b10));

    // R6: no input is taken while codes are being emitted.
    p_no_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R6: accepting the final code reopens the input.
    p_reopen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (in_ready && !out_valid));

    // R9: a stalled output holds steady.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_code)
            && $stable(out_scale) && $stable(out_last)));

    // R2: the scale does not change within a block.
    p_scale_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last) |=> (out_valid && $stable(out_scale)));

endmodule

bind tq_absmean tq_absmean_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_code  (out_code),
    .out_scale (out_scale),
    .out_last  (out_last)
);

// File: tb/tq_absmean_test.sv
// Scoreboard bench: the driver computes the expected codes for each block
// and queues them; a monitor pops and compares them on each output transfer.
module tq_absmean_test;

    localparam int W   = 16;
    localparam int N   = 16;
    localparam int EPS = 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W-1:0] in_data = '0;
    logic         in_last = 1'b0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [1:0]   out_code;
    logic [W-1:0] out_scale;
    logic         out_last;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ready_mode = 0;
    logic [W+2:0] exp_q[$];
    string        tag_q[$];
    int           wq[$];

    logic         stall_prev = 1'b0;
    logic [1:0]   held_code;
    logic [W-1:0] held_scale;
    logic         held_last;

    always #2 clk = ~clk;

    tq_absmean #(.WIDTH(W), .DEPTH(N), .EPS(EPS)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_last   (in_last),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_code  (out_code),
        .out_scale (out_scale),
        .out_last  (out_last)
    );

    // Cycle counter and downstream ready pattern.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1;
        out_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
    end

    // Compute the expected items for the block held in wq.
    task automatic push_block(input string tag);
        int s = 0;
        for (int i = 0; i < wq.size(); i++) s += (wq[i] < 0) ? -wq[i] : wq[i];
        for (int i = 0; i < wq.size(); i++) begin
            int m = (wq[i] < 0) ? -wq[i] : wq[i];
            logic [1:0] c;
            c = (2 * N * m >= s + N * EPS) ? ((wq[i] < 0) ? 2'b11 : 2'b01) : 2'b00;
            exp_q.push_back({(i == wq.size() - 1), W'(s / N), c});
            tag_q.push_back(tag);
        end
    endtask

    // Drive the block held in wq; in_last on its final weight when use_last is set.
    task automatic send_block(input string tag, input bit use_last);
        push_block(tag);
        for (int i = 0; i < wq.size(); i++) begin
            in_valid = 1'b1;
            in_data  = W'(wq[i]);
            in_last  = use_last && (i == wq.size() - 1);
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            @(posedge clk);
            #1;
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    // Monitor: hold rule, input refusal and scoreboard compare.
    always @(negedge clk) begin
        if (rst_n) begin
            if (stall_prev) begin
                checks++;
                if (!out_valid || out_code != held_code || out_scale != held_scale || out_last != held_last) begin
                    errors++;
                    $display("FAIL R9 stalled output moved: got v=%0b c=%b s=%0d l=%0b expected v=1 c=%b s=%0d l=%0b",
                             out_valid, out_code, out_scale, out_last, held_code, held_scale, held_last);
                end
            end
            stall_prev = out_valid && !out_ready;
            held_code  = out_code;
            held_scale = out_scale;
            held_last  = out_last;
            if (out_valid) begin
                checks++;
                if (in_ready) begin
                    errors++;
                    $display("FAIL R6 in_ready while emitting: got 1 expected 0");
                end
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R7 unexpected code: got %b expected none", out_code);
                end else begin
                    logic [W+2:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    checks++;
                    if (out_code != e[1:0] || out_code == 2'b10) begin
                        errors++;
                        $display("FAIL %s/R4 code: got %b expected %b", t, out_code, e[1:0]);
                    end
                    checks++;
                    if (out_scale != e[W+1:2]) begin
                        errors++;
                        $display("FAIL R2 (%s) scale: got %0d expected %0d", t, out_scale, e[W+1:2]);
                    end
                    checks++;
                    if (out_last != e[W+2]) begin
                        errors++;
                        $display("FAIL R7 (%s) last: got %0b expected %0b", t, out_last, e[W+2]);
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got hang expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (in_ready !== 1'b1 || out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset state: got ready=%0b valid=%0b expected ready=1 valid=0", in_ready, out_valid);
        end
        @(posedge clk);
        #1;

        // R3: mixed magnitudes and signs.
        wq = '{1000, -1000, 200, -50, 3000, -3000, 0, 400, -400, 800, 10, -10, 1500, -1500, 250, -250};
        send_block("R3", 1'b1);
        // R3: all zeros give zero codes and zero scale.
        wq = '{};
        for (int i = 0; i < N; i++) wq.push_back(0);
        send_block("R3", 1'b1);
        // R5: extreme values including the most negative.
        wq = '{-32768, 32767, -32768, 5, -5, 0, 1, -1, 100, -100, 2000, -2000, 16384, -16384, 7, 9};
        send_block("R5", 1'b1);
        // R3: every magnitude equal gives all nonzero codes.
        wq = '{};
        for (int i = 0; i < N; i++) wq.push_back((i % 2 == 0) ? 100 : -100);
        send_block("R3", 1'b1);

        ready_mode = 1;
        // R3: exact tie (all +1) rounds away from zero.
        wq = '{};
        for (int i = 0; i < N; i++) wq.push_back(1);
        send_block("R3", 1'b1);
        // R3: just below the tie except the single 2.
        wq = '{};
        for (int i = 0; i < N; i++) wq.push_back((i == 7) ? 2 : 1);
        send_block("R3", 1'b1);
        // R3: negative tie.
        wq = '{};
        for (int i = 0; i < N; i++) wq.push_back(-1);
        send_block("R3", 1'b1);
        // R8: short block closed by in_last, padded statistics.
        wq = '{300, -40, 90, -600, 12, 0};
        send_block("R8", 1'b1);
        // R8: full block closed by count with in_last low.
        wq = '{};
        for (int i = 0; i < N; i++) wq.push_back((i * 37) % 200 - 100);
        send_block("R8", 1'b0);
        // R8: single-weight block.
        wq = '{-77};
        send_block("R8", 1'b1);

        while (exp_q.size() > 0) @(negedge clk);
        repeat (4) @(negedge clk);
        checks++;
        if (in_ready !== 1'b1 || out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R6 idle after final code: got ready=%0b valid=%0b expected ready=1 valid=0", in_ready, out_valid);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule